// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Engine

This block is one channel of a packet DMA. Software builds a singly linked chain of four-word buffer descriptors in a small descriptor RAM, then writes the address of the first descriptor into the channel's head register. The engine reads each descriptor, hands its buffer address and length to a transfer agent, and waits for that agent to finish. It then writes the status word back so that ownership returns to the host, and follows the next link.

The descriptor RAM sits behind a synchronous port: an address is presented with the enable, and the read word comes back one cycle later. The data path is reduced to a request/done handshake. The host acknowledges each finished descriptor by writing its address into the acknowledge register, and the interrupt request stays high until that happens. A receive-side instance keeps a count of free buffers and does not fetch a descriptor while the count is zero. A teardown request stops the chain and ends with a fixed marker value in the acknowledge register, which the host must confirm.

Descriptor word order at byte offsets 0/4/8/12 is: next link, buffer address, buffer length, status word. Status bits: 31 first-segment, 30 last-segment, 29 owner, 28 end-of-queue, 27 teardown-done, 26 keep-checksum, 10:0 length. Host register select codes on `host_sel`: 0 head, 1 acknowledge, 2 enable, 3 free-buffer add, 4 teardown. Descriptors are 16-byte aligned.

Top module: `dchain_dma_chan`

## Requirements
- R1: After reset the head, acknowledge and free-count outputs are zero, the interrupt request is low, the channel is disabled, and neither the RAM port nor the transfer request is active.
- R2: A nonzero head write (select 0) is accepted only while the channel is idle (head is zero, no teardown pending or awaiting confirmation). A head write at any other time leaves the head unchanged. The engine reads the four words at head+0, +4, +8, +12 in that order.
- R3: After fetching, the engine raises the transfer request with the buffer address and bits 10:0 of the length word, and holds both steady until transfer-done.
- R4: After the transfer the engine writes only the status word, at offset 12. Bit 29 is cleared, bits 10:0 hold the length sent, and other bits are kept. If the next link is zero, bit 28 is set and the head returns to zero. Otherwise the head takes the next link.
- R5: The next link is taken as read at fetch time. A link written into the tail after its first word was fetched is not followed; that tail ends with bit 28 set, and a later head write restarts the chain.
- R6: The interrupt request is high while the address of the last written-back descriptor differs from the acknowledge register (select 1). Writing that address drops the request.
- R7: Enable (select 2, bit 0) gates fetching. While it is 0, an accepted head causes no RAM access.
- R8: On a receive instance, a free-add write (select 3) adds its value to the free count. A zero count stalls the channel before fetch, and each fetched descriptor takes one from the count. An add in the same cycle as a fetch gives old + N - 1.
- R9: A teardown write (select 4) whose bits 2:0 equal the channel number, arriving while a descriptor is in flight, lets that transfer finish. The write-back then sets bit 27, with bit 29 cleared and bit 28 clear. The acknowledge register becomes 0xFFFFFFFC, the head becomes zero, and no later descriptor is fetched.
- R10: A matching teardown while idle sets the acknowledge register to 0xFFFFFFFC on the second clock edge after the write, with no RAM access.
- R11: After a teardown the interrupt request stays high and head writes are ignored. This lasts until the host writes 0xFFFFFFFC to the acknowledge register.
- R12: A teardown write naming another channel number has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_sel | input | 3 | Host register select |
| host_wdata | input | 32 | Host write data |
| ram_en | output | 1 | Descriptor RAM access enable |
| ram_we | output | 1 | Descriptor RAM write |
| ram_addr | output | 32 | Descriptor RAM byte address |
| ram_wdata | output | 32 | Descriptor RAM write data |
| ram_rdata | input | 32 | Descriptor RAM read data, one cycle after the read |
| xfer_req | output | 1 | Buffer transfer request |
| xfer_addr | output | 32 | Buffer address of the transfer |
| xfer_len | output | LEN_W | Transfer length |
| xfer_done | input | 1 | Transfer finished pulse |
| hdp_o | output | 32 | Head register: current descriptor, zero when idle |
| cp_o | output | 32 | Acknowledge register |
| free_o | output | FREE_W | Free receive buffer count |
| irq_o | output | 1 | Completion interrupt request |

## Verification
A host free-buffer add and a descriptor fetch that consumes a buffer can land on the same clock edge, so both touch the count together. The bench provokes this by watching the RAM port for the first-word read of a descriptor that was stalled on an empty count. In that same cycle it drives a free-add write, so the write and the consumption share one edge. It judges the outcome by the count afterwards, which must be the sum of old value and added value less one. A teardown request during an ongoing transfer is a second overlap, and it is judged by the status word and the acknowledge register.

// File: rtl/dchain_pkg.sv
package dchain_pkg;

    localparam logic [31:0] TD_MARK = 32'hFFFF_FFFC;

    localparam int ST_FIRST = 31;
    localparam int ST_LAST  = 30;
    localparam int ST_OWN   = 29;
    localparam int ST_EOQ   = 28;
    localparam int ST_TDONE = 27;
    localparam int ST_KEEPC = 26;

    typedef enum logic [2:0] {
        SEL_HEAD   = 3'd0,
        SEL_ACK    = 3'd1,
        SEL_ENABLE = 3'd2,
        SEL_FREE   = 3'd3,
        SEL_TEAR   = 3'd4
    } host_sel_e;

    typedef enum logic [2:0] {
        W_IDLE, W_RD0, W_RD1, W_RD2, W_RD3, W_MODE, W_XFER, W_WB
    } walk_st_e;

    typedef struct packed {
        walk_st_e    st;
        logic [31:0] cur;
        logic [31:0] nxt;
        logic [31:0] bptr;
        logic [31:0] blen;
        logic [31:0] mode;
        logic [31:0] last_wb;
        logic        td_pend;
    } walk_s;

    typedef struct packed {
        logic        en;
        logic        tdw;
        logic [31:0] cp;
    } ack_s;

endpackage

// File: rtl/dchain_freecnt.sv
module dchain_freecnt
    import dchain_pkg::*;
#(
    parameter int IS_RX  = 1,
    parameter int FREE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [2:0]        host_sel,
    input  logic [FREE_W-1:0] add_val,
    input  logic              consume,
    output logic [FREE_W-1:0] free_o,
    output logic              free_ok
);

    generate
        if (IS_RX != 0) begin : g_rx
            logic [FREE_W-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (host_wr && host_sel == SEL_FREE)
                    cnt_d = cnt_d + add_val;
                if (consume)
                    cnt_d = cnt_d - FREE_W'(1);
            end

            always_ff @(posedge clk) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign free_o  = cnt_q;
            assign free_ok = (cnt_q != '0);
        end else begin : g_tx
            assign free_o  = '0;
            assign free_ok = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/dchain_ackregs.sv
module dchain_ackregs
    import dchain_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic [2:0]  host_sel,
    input  logic [31:0] host_wdata,
    input  logic        td_fire,
    input  logic [31:0] last_wb,
    output logic        en_o,
    output logic        td_wait_o,
    output logic [31:0] cp_o,
    output logic        irq_o
);

    ack_s d, q;

    always_comb begin
        d = q;
        if (host_wr && host_sel == SEL_ENABLE)
            d.en = host_wdata[0];
        if (host_wr && host_sel == SEL_ACK) begin
            d.cp = host_wdata;
            if (host_wdata == TD_MARK)
                d.tdw = 1'b0;
        end
        // the engine's marker write wins over a host write in the same cycle
        if (td_fire) begin
            d.cp  = TD_MARK;
            d.tdw = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign en_o      = q.en;
    assign td_wait_o = q.tdw;
    assign cp_o      = q.cp;
    assign irq_o     = (last_wb != q.cp) || q.tdw;

endmodule

// File: rtl/dchain_walker.sv
module dchain_walker
    import dchain_pkg::*;
#(
    parameter int          LEN_W   = 11,
    parameter int          CH_W    = 3,
    parameter int unsigned CHAN_ID = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr,
    input  logic [2:0]       host_sel,
    input  logic [31:0]      host_wdata,
    input  logic             en,
    input  logic             td_wait,
    input  logic             free_ok,
    output logic             ram_en,
    output logic             ram_we,
    output logic [31:0]      ram_addr,
    output logic [31:0]      ram_wdata,
    input  logic [31:0]      ram_rdata,
    output logic             xfer_req,
    output logic [31:0]      xfer_addr,
    output logic [LEN_W-1:0] xfer_len,
    input  logic             xfer_done,
    output logic [31:0]      head_o,
    output logic [31:0]      last_wb_o,
    output logic             consume_o,
    output logic             td_fire_o
);

    localparam logic [CH_W-1:0] MY_ID = CH_W'(CHAN_ID);

    walk_s d, q;
    logic        head_wr, tear_wr, td_now;
    logic [31:0] wb_word;

    assign head_wr = host_wr && host_sel == SEL_HEAD;
    assign tear_wr = host_wr && host_sel == SEL_TEAR
                     && host_wdata[CH_W-1:0] == MY_ID;
    assign td_now  = q.td_pend || tear_wr;

    always_comb begin
        wb_word          = q.mode;
        wb_word[ST_OWN]  = 1'b0;
        wb_word[LEN_W-1:0] = q.blen[LEN_W-1:0];
        if (td_now)
            wb_word[ST_TDONE] = 1'b1;
        else if (q.nxt == '0)
            wb_word[ST_EOQ] = 1'b1;
    end

    always_comb begin
        d         = q;
        ram_en    = 1'b0;
        ram_we    = 1'b0;
        ram_addr  = '0;
        ram_wdata = '0;
        xfer_req  = 1'b0;
        consume_o = 1'b0;
        td_fire_o = 1'b0;

        if (tear_wr)
            d.td_pend = 1'b1;
        if (head_wr && q.st == W_IDLE && q.cur == '0 && !td_wait && !q.td_pend)
            d.cur = host_wdata;

        case (q.st)
            W_IDLE: begin
                if (q.td_pend) begin
                    d.td_pend = 1'b0;
                    d.cur     = '0;
                    d.last_wb = TD_MARK;
                    td_fire_o = 1'b1;
                end else if (q.cur != '0 && en && !td_wait && free_ok) begin
                    d.st = W_RD0;
                end
            end
            W_RD0: begin
                ram_en    = 1'b1;
                ram_addr  = q.cur;
                consume_o = 1'b1;
                d.st      = W_RD1;
            end
            W_RD1: begin
                d.nxt    = ram_rdata;
                ram_en   = 1'b1;
                ram_addr = q.cur + 32'd4;
                d.st     = W_RD2;
            end
            W_RD2: begin
                d.bptr   = ram_rdata;
                ram_en   = 1'b1;
                ram_addr = q.cur + 32'd8;
                d.st     = W_RD3;
            end
            W_RD3: begin
                d.blen   = ram_rdata;
                ram_en   = 1'b1;
                ram_addr = q.cur + 32'd12;
                d.st     = W_MODE;
            end
            W_MODE: begin
                d.mode = ram_rdata;
                d.st   = W_XFER;
            end
            W_XFER: begin
                xfer_req = 1'b1;
                if (xfer_done)
                    d.st = W_WB;
            end
            W_WB: begin
                ram_en    = 1'b1;
                ram_we    = 1'b1;
                ram_addr  = q.cur + 32'd12;
                ram_wdata = wb_word;
                d.st      = W_IDLE;
                if (td_now) begin
                    d.td_pend = 1'b0;
                    d.cur     = '0;
                    d.last_wb = TD_MARK;
                    td_fire_o = 1'b1;
                end else begin
                    d.last_wb = q.cur;
                    d.cur     = q.nxt;
                end
            end
            default: d.st = W_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign xfer_addr = q.bptr;
    assign xfer_len  = q.blen[LEN_W-1:0];
    assign head_o    = q.cur;
    assign last_wb_o = q.last_wb;

endmodule

// File: rtl/dchain_dma_chan.sv
module dchain_dma_chan
    import dchain_pkg::*;
#(
    parameter int          LEN_W   = 11,
    parameter int          FREE_W  = 16,
    parameter int          CH_W    = 3,
    parameter int unsigned CHAN_ID = 0,
    parameter int          IS_RX   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [2:0]        host_sel,
    input  logic [31:0]       host_wdata,
    output logic              ram_en,
    output logic              ram_we,
    output logic [31:0]       ram_addr,
    output logic [31:0]       ram_wdata,
    input  logic [31:0]       ram_rdata,
    output logic              xfer_req,
    output logic [31:0]       xfer_addr,
    output logic [LEN_W-1:0]  xfer_len,
    input  logic              xfer_done,
    output logic [31:0]       hdp_o,
    output logic [31:0]       cp_o,
    output logic [FREE_W-1:0] free_o,
    output logic              irq_o
);

    logic        en, td_wait, free_ok, consume, td_fire;
    logic [31:0] last_wb;

    dchain_walker #(
        .LEN_W(LEN_W), .CH_W(CH_W), .CHAN_ID(CHAN_ID)
    ) walk_i (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_sel(host_sel), .host_wdata(host_wdata),
        .en(en), .td_wait(td_wait), .free_ok(free_ok),
        .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .xfer_req(xfer_req), .xfer_addr(xfer_addr), .xfer_len(xfer_len),
        .xfer_done(xfer_done),
        .head_o(hdp_o), .last_wb_o(last_wb),
        .consume_o(consume), .td_fire_o(td_fire)
    );

    dchain_ackregs ack_i (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_sel(host_sel), .host_wdata(host_wdata),
        .td_fire(td_fire), .last_wb(last_wb),
        .en_o(en), .td_wait_o(td_wait), .cp_o(cp_o), .irq_o(irq_o)
    );

    dchain_freecnt #(
        .IS_RX(IS_RX), .FREE_W(FREE_W)
    ) free_i (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_sel(host_sel),
        .add_val(host_wdata[FREE_W-1:0]),
        .consume(consume), .free_o(free_o), .free_ok(free_ok)
    );

endmodule

// File: rtl/dchain_dma_chan_chk.sv
module dchain_dma_chan_chk
    import dchain_pkg::*;
#(
    parameter int FREE_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic [2:0]        host_sel,
    input logic              ram_en,
    input logic              ram_we,
    input logic [31:0]       ram_wdata,
    input logic              xfer_req,
    input logic              xfer_done,
    input logic [31:0]       xfer_addr,
    input logic [31:0]       hdp_o,
    input logic [31:0]       cp_o,
    input logic [FREE_W-1:0] free_o
);

    // R3: request and buffer address stay put until done arrives
    a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_done) |=> (xfer_req && $stable(xfer_addr)));

    // R3: no descriptor RAM traffic while a buffer is moving
    a_r3_ram_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> !ram_en);

    // R4: every write-back releases ownership
    a_r4_owner_released: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> !ram_wdata[ST_OWN]);

    // R8: an empty count only leaves zero through a host add
    a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (free_o == '0 && !(host_wr && host_sel == SEL_FREE)) |=> free_o == '0);

    // R9: the marker appearing from the engine side leaves the head empty
    a_r9_marker_drops_chain: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_o == TD_MARK && $past(cp_o) != TD_MARK
         && !$past(host_wr && host_sel == SEL_ACK)) |-> hdp_o == '0);

endmodule

bind dchain_dma_chan dchain_dma_chan_chk #(.FREE_W(FREE_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .ram_en(ram_en), .ram_we(ram_we), .ram_wdata(ram_wdata),
    .xfer_req(xfer_req), .xfer_done(xfer_done), .xfer_addr(xfer_addr),
    .hdp_o(hdp_o), .cp_o(cp_o), .free_o(free_o)
);

// File: tb/dchain_dma_chan_tb.sv
module dchain_dma_chan_tb_top;

    localparam logic [31:0] MARK   = 32'hFFFF_FFFC;
    localparam logic [31:0] M_OWN  = 32'hE400_0003;
    localparam logic [31:0] M_EOQ  = 32'hD400_0000;
    localparam logic [31:0] M_MID  = 32'hC400_0000;
    localparam logic [31:0] M_TD   = 32'hCC00_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [2:0]  host_sel = 3'd0;
    logic [31:0] host_wdata = '0;
    logic        ram_en, ram_we;
    logic [31:0] ram_addr, ram_wdata;
    logic [31:0] ram_rdata = '0;
    logic        xfer_req;
    logic [31:0] xfer_addr;
    logic [10:0] xfer_len;
    logic        xfer_done = 1'b0;
    logic [31:0] hdp_o, cp_o;
    logic [15:0] free_o;
    logic        irq_o;

    int n_chk = 0;
    int n_err = 0;

    logic [31:0] mem [0:63];
    logic [31:0] rd_log [0:63];
    int rd_n = 0;
    int rd_c0 = 0;
    int xfer_lat = 3;
    int xwait = 0;
    int xfer_n = 0;
    logic [31:0] xa_log [0:15];
    logic [10:0] xl_log [0:15];

    always #4 clk = ~clk;

    dchain_dma_chan dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .ram_en(ram_en), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .xfer_req(xfer_req), .xfer_addr(xfer_addr), .xfer_len(xfer_len),
        .xfer_done(xfer_done), .hdp_o(hdp_o), .cp_o(cp_o),
        .free_o(free_o), .irq_o(irq_o)
    );

    // descriptor RAM model, one-cycle read latency
    always @(posedge clk) begin
        if (ram_en) begin
            if (ram_we) begin
                mem[ram_addr[7:2]] <= ram_wdata;
            end else begin
                ram_rdata <= mem[ram_addr[7:2]];
                if (rd_n < 64) rd_log[rd_n] = ram_addr;
                rd_n++;
                if (ram_addr[31:4] == 28'hC) rd_c0++;
            end
        end
    end

    // transfer agent with programmable latency
    always @(posedge clk) begin
        xfer_done <= 1'b0;
        if (xfer_req && !xfer_done) begin
            if (xwait >= xfer_lat) begin
                xfer_done <= 1'b1;
                if (xfer_n < 16) begin
                    xa_log[xfer_n] = xfer_addr;
                    xl_log[xfer_n] = xfer_len;
                end
                xfer_n++;
                xwait = 0;
            end else begin
                xwait++;
            end
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] val);
        @(negedge clk);
        host_wr = 1'b1; host_sel = sel; host_wdata = val;
        @(negedge clk);
        host_wr = 1'b0; host_sel = 3'd0; host_wdata = '0;
    endtask

    task automatic mk_desc(input logic [31:0] a, input logic [31:0] nx,
                           input logic [31:0] bp, input logic [31:0] ln);
        mem[a[7:2]]     = nx;
        mem[a[7:2] + 1] = bp;
        mem[a[7:2] + 2] = ln;
        mem[a[7:2] + 3] = M_OWN;
    endtask

    task automatic wait_idle();
        while (hdp_o != '0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 head", hdp_o, 32'h0);
        check("R1 ack", cp_o, 32'h0);
        check("R1 free", 32'(free_o), 32'h0);
        check("R1 irq", 32'(irq_o), 32'h0);
        check("R1 ram/xfer idle", {30'h0, ram_en, xfer_req}, 32'h0);
    endtask

    task automatic t_single();
        mk_desc(32'h40, 32'h0, 32'h1000, 32'h0000_0840);
        wr(3'd3, 32'd4);
        check("R8 free add", 32'(free_o), 32'd4);
        wr(3'd0, 32'h40);
        check("R2 head accepted", hdp_o, 32'h40);
        repeat (10) @(negedge clk);
        check("R7 no fetch while disabled", 32'(rd_n), 32'd0);
        wr(3'd2, 32'd1);
        wait_idle();
        check("R2 read order w0", rd_log[0], 32'h40);
        check("R2 read order w1", rd_log[1], 32'h44);
        check("R2 read order w2", rd_log[2], 32'h48);
        check("R2 read order w3", rd_log[3], 32'h4C);
        check("R3 xfer count", 32'(xfer_n), 32'd1);
        check("R3 xfer addr", xa_log[0], 32'h1000);
        check("R3 xfer len low bits", 32'(xl_log[0]), 32'h040);
        check("R4 status eoq", mem[8'h4C >> 2], M_EOQ | 32'h040);
        check("R4 head cleared", hdp_o, 32'h0);
        check("R8 consumed", 32'(free_o), 32'd3);
        check("R6 irq raised", 32'(irq_o), 32'd1);
        wr(3'd1, 32'h40);
        check("R6 irq dropped", 32'(irq_o), 32'd0);
    endtask

    task automatic t_chain();
        int base = xfer_n;
        mk_desc(32'h50, 32'h60, 32'h2000, 32'd10);
        mk_desc(32'h60, 32'h70, 32'h2100, 32'd20);
        mk_desc(32'h70, 32'h00, 32'h2200, 32'd30);
        mk_desc(32'h80, 32'h00, 32'h2300, 32'd40);
        wr(3'd0, 32'h50);
        while (!xfer_req) @(negedge clk);
        wr(3'd0, 32'h80);
        wait_idle();
        check("R4 chain transfers", 32'(xfer_n - base), 32'd3);
        check("R4 mid status no eoq", mem[8'h5C >> 2], M_MID | 32'd10);
        check("R4 mid status 2", mem[8'h6C >> 2], M_MID | 32'd20);
        check("R4 tail eoq", mem[8'h7C >> 2], M_EOQ | 32'd30);
        check("R2 busy head write ignored", mem[8'h8C >> 2], M_OWN);
        check("R8 count drained", 32'(free_o), 32'd0);
        wr(3'd1, 32'h70);
        check("R6 ack last", 32'(irq_o), 32'd0);
    endtask

    task automatic t_stall_and_collide();
        int r0 = rd_n;
        wr(3'd0, 32'h80);
        repeat (8) @(negedge clk);
        check("R8 stall no fetch", 32'(rd_n - r0), 32'd0);
        check("R8 stall head kept", hdp_o, 32'h80);
        wr(3'd3, 32'd2);
        while (!(ram_en && !ram_we && ram_addr == 32'h80)) @(negedge clk);
        // same edge as the consumption of one buffer
        host_wr = 1'b1; host_sel = 3'd3; host_wdata = 32'd5;
        @(negedge clk);
        host_wr = 1'b0; host_sel = 3'd0; host_wdata = '0;
        check("R8 add with consume", 32'(free_o), 32'd6);
        wait_idle();
        check("R8 desc done", mem[8'h8C >> 2], M_EOQ | 32'd40);
        wr(3'd1, 32'h80);
    endtask

    task automatic t_misqueue();
        int base = xfer_n;
        mk_desc(32'h90, 32'h0, 32'h3000, 32'd7);
        mk_desc(32'hA0, 32'h0, 32'h3100, 32'd8);
        wr(3'd0, 32'h90);
        while (!(ram_en && ram_addr == 32'h94)) @(negedge clk);
        mem[8'h90 >> 2] = 32'hA0;
        wait_idle();
        check("R5 late link unseen", 32'(xfer_n - base), 32'd1);
        check("R5 tail eoq", mem[8'h9C >> 2], M_EOQ | 32'd7);
        check("R5 head idle", hdp_o, 32'h0);
        wr(3'd0, 32'hA0);
        wait_idle();
        check("R5 restart", 32'(xfer_n - base), 32'd2);
        check("R5 restart status", mem[8'hAC >> 2], M_EOQ | 32'd8);
        wr(3'd1, 32'hA0);
    endtask

    task automatic t_other_channel();
        wr(3'd4, 32'd3);
        repeat (4) @(negedge clk);
        check("R12 ack untouched", cp_o, 32'hA0);
        check("R12 irq quiet", 32'(irq_o), 32'd0);
    endtask

    task automatic t_teardown_busy();
        int base = xfer_n;
        xfer_lat = 20;
        mk_desc(32'hB0, 32'hC0, 32'h4000, 32'd11);
        mk_desc(32'hC0, 32'h00, 32'h4100, 32'd12);
        wr(3'd0, 32'hB0);
        while (!xfer_req) @(negedge clk);
        wr(3'd4, 32'd0);
        while (cp_o != MARK) @(negedge clk);
        @(negedge clk);
        check("R9 transfer finished", 32'(xfer_n - base), 32'd1);
        check("R9 status teardown bit", mem[8'hBC >> 2], M_TD | 32'd11);
        check("R9 head dropped", hdp_o, 32'h0);
        check("R9 rest not fetched", 32'(rd_c0), 32'd0);
        check("R11 irq high", 32'(irq_o), 32'd1);
        wr(3'd0, 32'hC0);
        check("R11 head blocked", hdp_o, 32'h0);
        wr(3'd1, MARK);
        check("R11 confirmed irq low", 32'(irq_o), 32'd0);
        xfer_lat = 3;
        wr(3'd0, 32'hC0);
        check("R11 head accepted again", hdp_o, 32'hC0);
        wait_idle();
        check("R11 follow-up done", mem[8'hCC >> 2], M_EOQ | 32'd12);
        wr(3'd1, 32'hC0);
    endtask

    task automatic t_teardown_idle();
        int r0 = rd_n;
        wr(3'd4, 32'd0);
        @(negedge clk);
        check("R10 marker", cp_o, MARK);
        check("R10 no ram access", 32'(rd_n - r0), 32'd0);
        check("R11 irq after idle teardown", 32'(irq_o), 32'd1);
        wr(3'd1, MARK);
        check("R11 irq cleared", 32'(irq_o), 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_chain();
        t_stall_and_collide();
        t_misqueue();
        t_other_channel();
        t_teardown_busy();
        t_teardown_idle();
        summary();
        $finish;
    end

endmodule